// File: doc/BRIEF.md
# Timer Compare Output Unit

The block holds two 16-bit up-counting timers and a 16-bit compare value. Each clock it compares the compare value with the count of the timer picked by a select input. When the selected count reaches the compare value, a 4-bit mode code decides what happens. The output latch can be set, cleared or toggled, and an interrupt flag is raised in each of these modes. One mode raises only the flag. Another mode issues a one-cycle event pulse. That pulse zeroes the selected timer on the next clock, so the compare value works as a period register. The same pulse can also request a converter start.

A match is recognised once, when the selected count first arrives at the compare value. A timer that is held on that value gives no further matches. Writing a zero mode code forces the output latch low. The pin shows the latch only while the output enable is high.

Top module: `timer_compare_unit`

## Requirements
- R1: Each timer is set to zero when its clear input is high, or when it receives an event reset. Otherwise it adds one when its increment input is high, wrapping past 16'hFFFF, and otherwise it holds. The two timers are independent.
- R2: The compare value is checked against timer A when `tsel_i`=0 and against timer B when `tsel_i`=1. A match is registered only in the cycle in which the equality first becomes true, so a held count gives one match.
- R3: On the clock after a match, mode 4'b1000 sets the latch, 4'b1001 clears it, and 4'b0010 inverts it.
- R4: A match in any of the modes 4'b1000, 4'b1001, 4'b0010, 4'b1010 or 4'b1011 sets `flag_o` on the next clock. In every other mode code a match changes neither the flag nor the latch.
- R5: `flag_o` stays set until the cycle after `flag_clr_i` is high. If a set and a clear fall in the same cycle, the flag is set.
- R6: In mode 4'b1010 a match sets the flag and leaves the latch unchanged.
- R7: In mode 4'b1011, `evt_o` is high for the match cycle. The selected timer reads zero after the next clock, overriding its increment, so a timer that increments every clock has a period of compare value plus one.
- R8: `adc_start_o` is high exactly when `evt_o` is high and `adc_en_i` is high.
- R9: Writing mode 4'b0000 through `ctl_wr_i` clears the latch on that clock. This takes priority over any match action in the same cycle.
- R10: `pin_oe_o` follows `oe_i`. `pin_o` equals the latch while `oe_i`=1 and is 0 while `oe_i`=0.
- R11: While reset is held, both counts, the compare value, the mode, the latch and the flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_a_i | input | 1 | Increment enable, timer A |
| inc_b_i | input | 1 | Increment enable, timer B |
| clr_a_i | input | 1 | Synchronous clear, timer A |
| clr_b_i | input | 1 | Synchronous clear, timer B |
| tsel_i | input | 1 | Time base select (0 = A, 1 = B) |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_val_i | input | 16 | Compare value to write |
| ctl_wr_i | input | 1 | Mode write strobe |
| ctl_val_i | input | 4 | Mode code to write |
| flag_clr_i | input | 1 | Interrupt flag clear |
| adc_en_i | input | 1 | Converter enable |
| oe_i | input | 1 | Pin output enable |
| cnt_a_o | output | 16 | Timer A count |
| cnt_b_o | output | 16 | Timer B count |
| flag_o | output | 1 | Interrupt flag |
| evt_o | output | 1 | Special event pulse |
| adc_start_o | output | 1 | Converter start request |
| pin_o | output | 1 | Compare pin value |
| pin_oe_o | output | 1 | Pin driven indicator |

## Verification
Several properties are checked on every cycle:
- a match never lasts two cycles;
- a match in a valid mode sets the flag;
- the flag holds until it is cleared;
- the software-only mode and the unused codes leave the latch alone;
- an event zeroes the selected timer;
- a zero mode write clears the latch.

Other behaviour needs the bench scenarios, which compare every output each clock with a behavioural model:
- the choice of set, clear or toggle;
- the period of the event-reset timer;
- the single toggle on a held count;
- gating of the converter request;
- gating of the pin by the enable.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF = 4'b0000,
    MODE_TOG = 4'b0010,
    MODE_SET = 4'b1000,
    MODE_CLR = 4'b1001,
    MODE_SWI = 4'b1010,
    MODE_EVT = 4'b1011
  } mode_e;

  function automatic logic mode_active(input logic [MODE_W-1:0] m);
    return (m == MODE_TOG) || (m == MODE_SET) || (m == MODE_CLR) ||
           (m == MODE_SWI) || (m == MODE_EVT);
  endfunction
endpackage

// File: rtl/tcu_timer.sv
module tcu_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tcu_match.sv
module tcu_match #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_TMR = 2,
  localparam int unsigned SEL_W = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_TMR-1:0][CNT_W-1:0] cnts_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [CNT_W-1:0]            cmp_i,
  output logic                        match_o
);
  logic [CNT_W-1:0] cnt_sel;
  logic             eq, eq_q;

  always_comb begin
    cnt_sel = cnts_i[0];
    for (int i = 1; i < int'(N_TMR); i++)
      if (sel_i == SEL_W'(i)) cnt_sel = cnts_i[i];
  end

  assign eq = (cnt_sel == cmp_i);

  // rising edge of equality: one match per arrival
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  assign match_o = eq & ~eq_q;
endmodule

// File: rtl/tcu_action.sv
module tcu_action
  import tcu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              match_i,
  input  logic              force_low_i,
  input  logic              flag_clr_i,
  output logic              latch_o,
  output logic              flag_o,
  output logic              evt_o
);
  logic latch_q, latch_d, flag_q, hit;

  assign hit = match_i & mode_active(mode_i);

  always_comb begin
    latch_d = latch_q;
    if (force_low_i) latch_d = 1'b0;
    else if (match_i) begin
      unique case (mode_i)
        MODE_SET: latch_d = 1'b1;
        MODE_CLR: latch_d = 1'b0;
        MODE_TOG: latch_d = ~latch_q;
        default:  latch_d = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      if (hit)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign flag_o  = flag_q;
  assign evt_o   = match_i & (mode_i == MODE_EVT);
endmodule

// File: rtl/timer_compare_unit.sv
module timer_compare_unit
  import tcu_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_a_i,
  input  logic             inc_b_i,
  input  logic             clr_a_i,
  input  logic             clr_b_i,
  input  logic             tsel_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             ctl_wr_i,
  input  logic [3:0]       ctl_val_i,
  input  logic             flag_clr_i,
  input  logic             adc_en_i,
  input  logic             oe_i,
  output logic [CNT_W-1:0] cnt_a_o,
  output logic [CNT_W-1:0] cnt_b_o,
  output logic             flag_o,
  output logic             evt_o,
  output logic             adc_start_o,
  output logic             pin_o,
  output logic             pin_oe_o
);
  localparam int unsigned N_TMR = 2;

  logic [CNT_W-1:0]            cmp_q;
  logic [MODE_W-1:0]           mode_q;
  logic [N_TMR-1:0]            inc_v, clr_v;
  logic [N_TMR-1:0][CNT_W-1:0] cnts;
  logic                        match, latch, evt, force_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      if (cmp_wr_i) cmp_q  <= cmp_val_i;
      if (ctl_wr_i) mode_q <= ctl_val_i;
    end
  end

  assign inc_v     = {inc_b_i, inc_a_i};
  assign force_low = ctl_wr_i & (ctl_val_i == MODE_OFF);

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    logic ext_clr;
    assign ext_clr  = (g == 0) ? clr_a_i : clr_b_i;
    assign clr_v[g] = ext_clr | (evt & (tsel_i == 1'(g)));
    tcu_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc_v[g]),
      .clr_i (clr_v[g]),
      .cnt_o (cnts[g])
    );
  end

  tcu_match #(.CNT_W(CNT_W), .N_TMR(N_TMR)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnts_i (cnts),
    .sel_i  (tsel_i),
    .cmp_i  (cmp_q),
    .match_o(match)
  );

  tcu_action u_act (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_q),
    .match_i    (match),
    .force_low_i(force_low),
    .flag_clr_i (flag_clr_i),
    .latch_o    (latch),
    .flag_o     (flag_o),
    .evt_o      (evt)
  );

  assign cnt_a_o     = cnts[0];
  assign cnt_b_o     = cnts[1];
  assign evt_o       = evt;
  assign adc_start_o = evt & adc_en_i;
  assign pin_oe_o    = oe_i;
  assign pin_o       = oe_i & latch;
endmodule

// File: rtl/tcu_chk.sv
module tcu_chk
  import tcu_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        match_i,
  input logic [3:0]  mode_i,
  input logic        latch_i,
  input logic        flag_o,
  input logic        flag_clr_i,
  input logic        evt_o,
  input logic        tsel_i,
  input logic        ctl_wr_i,
  input logic [3:0]  ctl_val_i,
  input logic [15:0] cnt_a_o,
  input logic [15:0] cnt_b_o
);
  assert_single_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> !match_i);

  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && mode_active(mode_i) |=> flag_o);

  assert_off_mode_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && !mode_active(mode_i) && !ctl_wr_i |=> $stable(latch_i));

  assert_flag_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o);

  assert_swi_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i && mode_i == MODE_SWI && !ctl_wr_i |=> $stable(latch_i));

  assert_evt_reset_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o && !tsel_i |=> cnt_a_o == 16'd0);

  assert_evt_reset_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o && tsel_i |=> cnt_b_o == 16'd0);

  assert_zero_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i && ctl_val_i == 4'd0 |=> !latch_i);
endmodule

bind timer_compare_unit tcu_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .match_i   (match),
  .mode_i    (mode_q),
  .latch_i   (latch),
  .flag_o    (flag_o),
  .flag_clr_i(flag_clr_i),
  .evt_o     (evt_o),
  .tsel_i    (tsel_i),
  .ctl_wr_i  (ctl_wr_i),
  .ctl_val_i (ctl_val_i),
  .cnt_a_o   (cnt_a_o),
  .cnt_b_o   (cnt_b_o)
);

// File: tb/timer_compare_unit_test.sv
module timer_compare_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic inc_a = 0, inc_b = 0, clr_a = 0, clr_b = 0, tsel = 0;
  logic cmp_wr = 0, ctl_wr = 0, flag_clr = 0, adc_en = 0, oe = 0;
  logic [15:0] cmp_val = 0;
  logic [3:0]  ctl_val = 0;
  logic [15:0] cnt_a, cnt_b;
  logic flag, evt, adc_start, pin, pin_oe;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R11";

  // behavioural model state
  logic [15:0] m_a = 0, m_b = 0, m_cmp = 0;
  logic [3:0]  m_mode = 0;
  logic        m_latch = 0, m_flag = 0, m_eq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_compare_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .inc_a_i(inc_a), .inc_b_i(inc_b),
    .clr_a_i(clr_a), .clr_b_i(clr_b), .tsel_i(tsel), .cmp_wr_i(cmp_wr),
    .cmp_val_i(cmp_val), .ctl_wr_i(ctl_wr), .ctl_val_i(ctl_val),
    .flag_clr_i(flag_clr), .adc_en_i(adc_en), .oe_i(oe),
    .cnt_a_o(cnt_a), .cnt_b_o(cnt_b), .flag_o(flag), .evt_o(evt),
    .adc_start_o(adc_start), .pin_o(pin), .pin_oe_o(pin_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s/%s %s: got %0h expected %0h (t=%0t)", req, phase, what, act, exp, $time);
    end
  endtask

  function automatic logic active(input logic [3:0] m);
    return m == 4'b0010 || m == 4'b1000 || m == 4'b1001 || m == 4'b1010 || m == 4'b1011;
  endfunction

  task automatic check_regs();
    chk("R1", "cnt_a_o", cnt_a, m_a);
    chk("R1", "cnt_b_o", cnt_b, m_b);
    chk("R5", "flag_o", flag, m_flag);
    chk("R10", "pin_oe_o", pin_oe, oe);
    chk("R3", "pin_o", pin, oe & m_latch);
  endtask

  // one clock: check comb outputs, advance model, check registered outputs
  task automatic cyc();
    logic [15:0] s;
    logic eq, match, ev;
    s     = tsel ? m_b : m_a;
    eq    = (s == m_cmp);
    match = eq && !m_eq;
    ev    = match && (m_mode == 4'b1011);
    #1;
    chk("R7", "evt_o", evt, ev);
    chk("R8", "adc_start_o", adc_start, ev & adc_en);
    @(posedge clk);
    m_eq = eq;
    if (clr_a || (ev && !tsel)) m_a = 0; else if (inc_a) m_a = m_a + 1;
    if (clr_b || (ev && tsel))  m_b = 0; else if (inc_b) m_b = m_b + 1;
    if (ctl_wr && ctl_val == 0) m_latch = 0;
    else if (match) begin
      if (m_mode == 4'b1000) m_latch = 1;
      else if (m_mode == 4'b1001) m_latch = 0;
      else if (m_mode == 4'b0010) m_latch = ~m_latch;
    end
    if (match && active(m_mode)) m_flag = 1; else if (flag_clr) m_flag = 0;
    if (ctl_wr) m_mode = ctl_val;
    if (cmp_wr) m_cmp = cmp_val;
    @(negedge clk);
    check_regs();
    cmp_wr = 0; ctl_wr = 0; clr_a = 0; clr_b = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic set_mode(input logic [3:0] m);
    ctl_wr = 1; ctl_val = m; cyc();
  endtask

  task automatic set_cmp(input logic [15:0] v);
    cmp_wr = 1; cmp_val = v; cyc();
  endtask

  initial begin
    #(CLK_PERIOD*2);
    @(negedge clk);
    phase = "R11";
    chk("R11", "cnt_a_o reset", cnt_a, 0);
    chk("R11", "cnt_b_o reset", cnt_b, 0);
    chk("R11", "flag_o reset", flag, 0);
    chk("R11", "pin_o reset", pin, 0);
    chk("R11", "evt_o reset", evt, 0);
    rst_ni = 1;
    run(2);

    phase = "R1";
    inc_a = 1; run(3);
    inc_b = 1; run(2);
    clr_b = 1; run(1);
    inc_a = 0; inc_b = 0; clr_a = 1; run(1);

    phase = "R3";
    oe = 1; set_cmp(16'd5); set_mode(4'b1000);
    inc_a = 1; run(9);
    flag_clr = 1; run(1); flag_clr = 0;
    set_mode(4'b1001); clr_a = 1; run(1); run(8);

    phase = "R2";
    set_mode(4'b0010); clr_a = 1; run(1);
    run(5); inc_a = 0; run(4); inc_a = 1; run(3);
    tsel = 1; inc_a = 0; clr_b = 1; run(1); inc_b = 1; run(8); inc_b = 0;

    phase = "R5";
    flag_clr = 1; clr_b = 1; inc_b = 1; run(8); flag_clr = 0; run(2);

    phase = "R6";
    set_mode(4'b1010); clr_b = 1; run(1); run(8);

    phase = "R4";
    set_mode(4'b0001); flag_clr = 1; run(1); flag_clr = 0;
    clr_b = 1; run(1); run(8);

    phase = "R7";
    set_cmp(16'd3); set_mode(4'b1011); clr_b = 1; run(1);
    run(12);
    phase = "R8";
    adc_en = 1; run(10);
    tsel = 0; inc_a = 1; clr_a = 1; run(1); run(10);
    adc_en = 0; inc_a = 0; inc_b = 0;

    phase = "R9";
    tsel = 0; set_mode(4'b1000); clr_a = 1; run(1);
    inc_a = 1; run(5); inc_a = 0; run(1);
    set_mode(4'b0000); run(2);
    set_mode(4'b1000); clr_a = 1; run(1);
    inc_a = 1; run(4);
    ctl_wr = 1; ctl_val = 4'b0000; run(1); run(2);

    phase = "R10";
    set_mode(4'b1000); clr_a = 1; run(1); run(7);
    oe = 0; run(3); oe = 1; run(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule